// File: doc/BRIEF.md
# MMIO Address to Isolation-Domain Mapper

This block decides which isolation domain owns a memory-mapped I/O access. It holds a small table of window entries. Each entry describes an aligned, power-of-two address range as a base and a mask. The entry also says how that range is turned into a domain number. The range can go to one fixed domain, or it can be cut into equal segments. A segmented range gives each segment a domain in one of three ways: by position, through a per-segment table, or by position plus a programmable base.

Software fills the table through a plain write port. One write updates a whole entry. A second write port fills per-segment domain slots. A write that breaks a segmenting rule is refused, and the entry keeps its previous contents.

Lookups use a valid/ready stream. An address offered with `lk_valid` is taken on a clock edge where `lk_ready` is high. Its result appears on the following cycle with `res_valid`. The result stays stable until the consumer raises `res_ready`. `lk_ready` is high whenever the result register is empty or is being drained in that cycle, so a stalled consumer stops new lookups from being accepted.

Top module: `mmio_dom_map`

## Requirements
- R1: After a synchronous active-high reset every entry is disabled, `res_valid` is low, and any lookup misses.
- R2: An entry matches when it is enabled and `(addr & mask) == (base & mask)`. When no entry matches, `res_hit` is 0, `res_dom` is 0 and `res_idx` is 0.
- R3: Mode code 0 (single) maps the whole range to the programmed domain `cfg_dom`.
- R4: Mode code 1 (split) cuts the range into DOM_COUNT segments. The segment index is taken from the address bits just below the lowest set bit of the mask, and segment n maps to domain n.
- R5: Mode code 2 (remap) cuts the range into LUT_SEGS segments. Each segment takes its domain from a per-entry slot written through `seg_we`/`seg_ent`/`seg_sel`/`seg_dom`.
- R6: Mode code 3 (offset) cuts the range into 8, 64 or 128 segments for `cfg_cnt` codes 0, 1 and 2. Segment n maps to `cfg_dom + n`.
- R7: An offset-mode write is refused when `cfg_cnt` is 3 or when `cfg_dom` is not a multiple of the segment count. A refused write leaves the entry unchanged.
- R8: A segmented write is refused when the range holds fewer addresses than it has segments, that is when the count of trailing zeros of the mask is below log2 of the segment count. A range exactly as large as the segment count is accepted.
- R9: When several enabled entries match, the lowest-numbered entry supplies the result.
- R10: An entry write affects lookups accepted on the next clock edge and later. A lookup accepted on the same edge as the write still sees the old entry.
- R11: A lookup is accepted when `lk_valid && lk_ready`. Its result shows on `res_valid` one cycle later. `lk_ready` equals `!res_valid || res_ready`. While `res_valid && !res_ready` the result holds stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry written |
| cfg_base | input | ADDR_W | Range base |
| cfg_mask | input | ADDR_W | Range mask (high ones) |
| cfg_mode | input | 2 | 0 single, 1 split, 2 remap, 3 offset |
| cfg_en | input | 1 | Entry enable |
| cfg_dom | input | DOM_W | Fixed domain (single) or base domain (offset) |
| cfg_cnt | input | 2 | Offset segment count code |
| seg_we | input | 1 | Segment slot write strobe |
| seg_ent | input | IDX_W | Entry whose slot is written |
| seg_sel | input | LSEG_W | Slot written |
| seg_dom | input | DOM_W | Domain stored in the slot |
| lk_valid | input | 1 | Lookup offered |
| lk_ready | output | 1 | Lookup can be taken |
| lk_addr | input | ADDR_W | Lookup address |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes result |
| res_hit | output | 1 | Some entry matched |
| res_dom | output | DOM_W | Domain number |
| res_idx | output | IDX_W | Winning entry |

## Verification
The bench checks the segment-index extraction at both ends of each segmented range: the first and last segment of a split, remap and offset window. A design whose shift is off by one would return a neighbouring domain there. It offers misaligned offset bases, an illegal count code, and a window one bit too narrow for its segments. A design missing a check would then hit where the bench expects the old, disabled or unchanged entry. Overlapping windows and a catch-all entry with a zero mask expose a reversed priority. Two further cases target the timing. A write issued in the same cycle as a lookup exposes a bypass that should not exist. A stalled consumer exposes a result that changes or a lookup accepted while blocked.

// File: rtl/mdm_pkg.sv
`timescale 1ns/1ps
package mdm_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_SPLIT  = 2'd1,
    MODE_REMAP  = 2'd2,
    MODE_OFFSET = 2'd3
  } mdm_mode_e;
endpackage

// File: rtl/mdm_entry.sv
`timescale 1ns/1ps
module mdm_entry
  import mdm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DOM_COUNT = 256,
  parameter int LUT_SEGS  = 16,
  localparam int DOM_W  = $clog2(DOM_COUNT),
  localparam int LSEG_W = $clog2(LUT_SEGS),
  localparam int SHW    = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  mdm_mode_e         cfg_mode,
  input  logic              cfg_en,
  input  logic [DOM_W-1:0]  cfg_dom,
  input  logic [1:0]        cfg_cnt,
  input  logic              seg_we,
  input  logic [LSEG_W-1:0] seg_sel,
  input  logic [DOM_W-1:0]  seg_dom,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [DOM_W-1:0]  dom
);
  // position of the lowest set mask bit; ADDR_W when the mask is empty
  function automatic logic [SHW-1:0] low_one(input logic [ADDR_W-1:0] m);
    logic [SHW-1:0] r;
    r = SHW'(ADDR_W);
    for (int i = ADDR_W - 1; i >= 0; i--)
      if (m[i]) r = SHW'(i);
    return r;
  endfunction

  logic              r_en;
  logic [ADDR_W-1:0] r_base;
  logic [ADDR_W-1:0] r_mask;
  mdm_mode_e         r_mode;
  logic [DOM_W-1:0]  r_dom;
  logic [SHW-1:0]    r_shift;
  logic [DOM_W-1:0]  r_segmask;
  logic [DOM_W-1:0]  slot [LUT_SEGS];

  // write qualification
  logic [SHW-1:0]   w_bits;
  logic [SHW-1:0]   w_tz;
  logic [DOM_W-1:0] w_segmask;
  logic             w_cnt_ok;
  logic             w_accept;

  always_comb begin
    w_cnt_ok = 1'b1;
    case (cfg_mode)
      MODE_SINGLE: w_bits = '0;
      MODE_SPLIT:  w_bits = SHW'(DOM_W);
      MODE_REMAP:  w_bits = SHW'(LSEG_W);
      default: begin
        case (cfg_cnt)
          2'd0:    w_bits = SHW'(3);
          2'd1:    w_bits = SHW'(6);
          2'd2:    w_bits = SHW'(7);
          default: begin w_bits = '0; w_cnt_ok = 1'b0; end
        endcase
      end
    endcase
    w_segmask = DOM_W'((32'd1 << w_bits) - 32'd1);
    w_tz      = low_one(cfg_mask);
    w_accept  = w_cnt_ok && (w_tz >= w_bits) &&
                ((cfg_mode != MODE_OFFSET) || ((cfg_dom & w_segmask) == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_en <= 1'b0;
    end else if (cfg_we && w_accept) begin
      r_en      <= cfg_en;
      r_base    <= cfg_base;
      r_mask    <= cfg_mask;
      r_mode    <= cfg_mode;
      r_dom     <= cfg_dom;
      r_shift   <= w_tz - w_bits;
      r_segmask <= w_segmask;
    end
  end

  always_ff @(posedge clk) begin
    if (seg_we) slot[seg_sel] <= seg_dom;
  end

  // lookup side
  logic [DOM_W-1:0] seg_idx;

  always_comb begin
    hit     = r_en && (((lk_addr ^ r_base) & r_mask) == '0);
    seg_idx = DOM_W'(lk_addr >> r_shift) & r_segmask;
    case (r_mode)
      MODE_SINGLE: dom = r_dom;
      MODE_SPLIT:  dom = seg_idx;
      MODE_REMAP:  dom = slot[seg_idx[LSEG_W-1:0]];
      default:     dom = r_dom + seg_idx;
    endcase
  end
endmodule

// File: rtl/mdm_prio.sv
`timescale 1ns/1ps
module mdm_prio #(
  parameter int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/mmio_dom_map.sv
`timescale 1ns/1ps
module mmio_dom_map
  import mdm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_ENT   = 16,
  parameter int DOM_COUNT = 256,
  parameter int LUT_SEGS  = 16,
  localparam int IDX_W  = $clog2(NUM_ENT),
  localparam int DOM_W  = $clog2(DOM_COUNT),
  localparam int LSEG_W = $clog2(LUT_SEGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_en,
  input  logic [DOM_W-1:0]  cfg_dom,
  input  logic [1:0]        cfg_cnt,
  input  logic              seg_we,
  input  logic [IDX_W-1:0]  seg_ent,
  input  logic [LSEG_W-1:0] seg_sel,
  input  logic [DOM_W-1:0]  seg_dom,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [DOM_W-1:0]  res_dom,
  output logic [IDX_W-1:0]  res_idx
);
  logic [NUM_ENT-1:0] ent_hit;
  logic [DOM_W-1:0]   ent_dom [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    mdm_entry #(
      .ADDR_W(ADDR_W), .DOM_COUNT(DOM_COUNT), .LUT_SEGS(LUT_SEGS)
    ) u_ent (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we && (cfg_idx == IDX_W'(g))),
      .cfg_base (cfg_base),
      .cfg_mask (cfg_mask),
      .cfg_mode (mdm_mode_e'(cfg_mode)),
      .cfg_en   (cfg_en),
      .cfg_dom  (cfg_dom),
      .cfg_cnt  (cfg_cnt),
      .seg_we   (seg_we && (seg_ent == IDX_W'(g))),
      .seg_sel  (seg_sel),
      .seg_dom  (seg_dom),
      .lk_addr  (lk_addr),
      .hit      (ent_hit[g]),
      .dom      (ent_dom[g])
    );
  end

  logic             win_found;
  logic [IDX_W-1:0] win_idx;

  mdm_prio #(.N(NUM_ENT)) u_prio (
    .req   (ent_hit),
    .found (win_found),
    .idx   (win_idx)
  );

  assign lk_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_dom   <= '0;
      res_idx   <= '0;
    end else if (lk_valid && lk_ready) begin
      res_valid <= 1'b1;
      res_hit   <= win_found;
      res_dom   <= win_found ? ent_dom[win_idx] : '0;
      res_idx   <= win_found ? win_idx : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mdm_checker.sv
`timescale 1ns/1ps
module mdm_checker #(
  parameter int DOM_W = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_hit,
  input logic [DOM_W-1:0] res_dom,
  input logic [IDX_W-1:0] res_idx
);
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid);

  a_r2_miss_is_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_dom == '0 && res_idx == '0));

  a_r11_accept_gives_result: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |=> res_valid);

  a_r11_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_hit) && $stable(res_dom) && $stable(res_idx)));

  a_r11_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |-> !lk_ready);

  a_r11_no_phantom: assert property (@(posedge clk) disable iff (rst)
    (!res_valid && !lk_valid) |=> !res_valid);
endmodule

bind mmio_dom_map mdm_checker #(.DOM_W(DOM_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_ready  (lk_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_hit   (res_hit),
  .res_dom   (res_dom),
  .res_idx   (res_idx)
);

// File: tb/mmio_dom_map_test.sv
`timescale 1ns/1ps
module mmio_dom_map_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0;
  logic [31:0] cfg_mask = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_en = 1'b0;
  logic [7:0]  cfg_dom = '0;
  logic [1:0]  cfg_cnt = '0;
  logic        seg_we = 1'b0;
  logic [3:0]  seg_ent = '0;
  logic [3:0]  seg_sel = '0;
  logic [7:0]  seg_dom = '0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [7:0]  res_dom;
  logic [3:0]  res_idx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mmio_dom_map uut (.*);

  typedef struct {
    logic       hit;
    logic [7:0] dom;
    logic [3:0] idx;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected results as the design delivers them
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11 unexpected result", {res_hit, res_dom, res_idx}, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(res_hit == e.hit && res_dom == e.dom && res_idx == e.idx, e.tag,
              {res_hit, res_dom, res_idx}, {e.hit, e.dom, e.idx});
        end
      end
    end
  end

  task automatic push(input bit h, input logic [7:0] d, input logic [3:0] i, input string tag);
    exp_t e;
    e.hit = h; e.dom = d; e.idx = i; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic look(input logic [31:0] a, input bit h, input logic [7:0] d,
                      input logic [3:0] i, input string tag);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = a;
    push(h, d, i, tag);
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic cfg(input logic [3:0] idx, input logic [31:0] base, input logic [31:0] mask,
                     input logic [1:0] mode, input bit en, input logic [7:0] dom,
                     input logic [1:0] cnt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_mask = mask;
    cfg_mode = mode; cfg_en = en; cfg_dom = dom; cfg_cnt = cnt;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic slot(input logic [3:0] ent, input logic [3:0] sel, input logic [7:0] dom);
    @(negedge clk);
    seg_we = 1'b1; seg_ent = ent; seg_sel = sel; seg_dom = dom;
    @(negedge clk);
    seg_we = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
    chk(lk_ready == 1'b1, "R11 ready when empty", lk_ready, 1);
    look(32'h0000_1000, 0, 8'h00, 4'd0, "R1 lookup after reset misses");

    // single mode
    cfg(4'd2, 32'h4000_0000, 32'hFFF0_0000, 2'd0, 1, 8'h2A, 2'd0);
    look(32'h4001_2345, 1, 8'h2A, 4'd2, "R3 single mode domain");
    look(32'h4010_0000, 0, 8'h00, 4'd0, "R2 just above range misses");

    // split mode: 16 MiB, 256 segments -> bits 23:16
    cfg(4'd3, 32'h8000_0000, 32'hFF00_0000, 2'd1, 1, 8'h00, 2'd0);
    look(32'h8037_0000, 1, 8'h37, 4'd3, "R4 split segment 0x37");
    look(32'h8000_FFFF, 1, 8'h00, 4'd3, "R4 split first segment");
    look(32'h80FF_FFFF, 1, 8'hFF, 4'd3, "R4 split last segment");

    // remap mode: 64 KiB, 16 segments -> bits 15:12
    slot(4'd4, 4'd5, 8'h77);
    slot(4'd4, 4'd15, 8'h03);
    slot(4'd4, 4'd0, 8'hC1);
    cfg(4'd4, 32'h9000_0000, 32'hFFFF_0000, 2'd2, 1, 8'h00, 2'd0);
    look(32'h9000_5ABC, 1, 8'h77, 4'd4, "R5 remap slot 5");
    look(32'h9000_F000, 1, 8'h03, 4'd4, "R5 remap last slot");
    look(32'h9000_0FFF, 1, 8'hC1, 4'd4, "R5 remap first slot");

    // offset mode: 4 KiB, 64 segments -> bits 11:6, base 0x40
    cfg(4'd5, 32'hA000_0000, 32'hFFFF_F000, 2'd3, 1, 8'h40, 2'd1);
    look(32'hA000_0240, 1, 8'h49, 4'd5, "R6 offset segment 9");
    look(32'hA000_0FC0, 1, 8'h7F, 4'd5, "R6 offset last segment");

    // refused offset writes keep the entry
    cfg(4'd5, 32'hA000_0000, 32'hFFFF_F000, 2'd3, 1, 8'h41, 2'd1);
    look(32'hA000_0240, 1, 8'h49, 4'd5, "R7 misaligned base refused");
    cfg(4'd5, 32'hA000_0000, 32'hFFFF_F000, 2'd3, 1, 8'h00, 2'd3);
    look(32'hA000_0240, 1, 8'h49, 4'd5, "R7 bad count code refused");
    cfg(4'd5, 32'hA000_0000, 32'hFFFF_F000, 2'd3, 1, 8'h48, 2'd0);
    look(32'hA000_0E00, 1, 8'h4F, 4'd5, "R6 eight segments base 0x48");

    // too-narrow segmented window refused; exact size accepted
    cfg(4'd6, 32'hB000_0000, 32'hFFFF_FF80, 2'd1, 1, 8'h00, 2'd0);
    look(32'hB000_0010, 0, 8'h00, 4'd0, "R8 narrow split refused");
    cfg(4'd6, 32'hB000_0000, 32'hFFFF_FF00, 2'd1, 1, 8'h00, 2'd0);
    look(32'hB000_0042, 1, 8'h42, 4'd6, "R8 exact size accepted");

    // priority
    cfg(4'd1, 32'h4000_0000, 32'hF000_0000, 2'd0, 1, 8'h11, 2'd0);
    look(32'h4001_2345, 1, 8'h11, 4'd1, "R9 lower entry wins overlap");
    look(32'h4800_0000, 1, 8'h11, 4'd1, "R9 only wide entry matches");
    cfg(4'd1, 32'h4000_0000, 32'hF000_0000, 2'd0, 0, 8'h11, 2'd0);
    look(32'h4001_2345, 1, 8'h2A, 4'd2, "R2 disabled entry ignored");

    // write and lookup on the same edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd7; cfg_base = 32'hC000_0000; cfg_mask = 32'hFFFF_0000;
    cfg_mode = 2'd0; cfg_en = 1'b1; cfg_dom = 8'h05; cfg_cnt = 2'd0;
    lk_valid = 1'b1; lk_addr = 32'hC000_0010;
    push(0, 8'h00, 4'd0, "R10 same-edge lookup sees old entry");
    @(negedge clk);
    cfg_we = 1'b0;
    push(1, 8'h05, 4'd7, "R10 next lookup sees new entry");
    @(negedge clk);
    lk_valid = 1'b0;

    // back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    lk_valid = 1'b1; lk_addr = 32'h4001_2345;
    push(1, 8'h2A, 4'd2, "R11 stalled result");
    @(negedge clk);
    lk_addr = 32'h0000_1000;
    push(0, 8'h00, 4'd0, "R11 lookup after stall");
    chk(res_valid == 1'b1, "R11 result present", res_valid, 1);
    chk(lk_ready == 1'b0, "R11 ready low while stalled", lk_ready, 0);
    repeat (2) begin
      @(negedge clk);
      chk(res_valid == 1'b1 && res_dom == 8'h2A && res_idx == 4'd2,
          "R11 result held during stall", {res_valid, res_dom, res_idx}, {1'b1, 8'h2A, 4'd2});
    end
    @(negedge clk);
    res_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);

    // catch-all entry at the highest index
    cfg(4'd15, 32'h0000_0000, 32'h0000_0000, 2'd0, 1, 8'h99, 2'd0);
    look(32'h0000_1000, 1, 8'h99, 4'd15, "R2 zero mask matches everything");
    look(32'h8037_0000, 1, 8'h37, 4'd3, "R9 lower entry beats catch-all");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11 every lookup answered", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule